// File: doc/BRIEF.md
# Countdown Interval Timer with Latched Count Readout

This block is a 32-bit down-counter that raises an interrupt each time it runs out. Software reaches it through a small word-addressed bus whose data registers are 16 bits wide. It loads the reload value as two halfwords and sets the interrupt enable and the reload mode. It issues start and stop strobes through a control word. A single level interrupt line follows the expiry flag while interrupts are enabled.

The live count is never read directly. Software writes to either snapshot location, which copies the whole counter into a 32-bit holding register in one clock. It then reads the two halves at its leisure. Both halves come from the same instant, even if a borrow ripples across the halfword boundary between the two reads. Elapsed time in the current interval is the reload value minus the captured count. Reads are registered: a read strobe returns data with a valid flag one clock later.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset every readable register returns zero, the counter is stopped and `irq` is low.
- R2: Word offsets: 0 status (bit 0 expired, bit 1 active), 1 control (bit 0 interrupt enable, bit 1 auto-reload, bit 2 start strobe, bit 3 stop strobe), 2 reload low half, 3 reload high half, 4 and 5 snapshot low and high halves. Control reads return only bits 1:0, and the strobe bits read as zero. Offsets 6 and 7 read as zero.
- R3: While active, the counter decrements once per clock. On the clock where it sits at zero it sets the expired flag. A reload value of N therefore gives an interval of N+1 clocks, and N=0 expires on the first clock after start.
- R4: With auto-reload off, an expiry clears the active bit and reloads the counter with the reload value.
- R5: With auto-reload on, an expiry reloads the counter with the reload value and the counter stays active, so expiries repeat every N+1 clocks.
- R6: `irq` is high exactly when the expired flag is set and the interrupt enable bit is 1. With the enable at 0, the flag still sets and remains visible in status.
- R7: Any write to offset 0 clears the expired flag, whatever the data. If an expiry occurs in the same clock, the flag stays set.
- R8: Any write to offset 4 or 5 copies the counter value from before that clock edge into both snapshot halves, and the written data is ignored. The snapshot holds until the next such write.
- R9: A stop strobe clears the active bit and freezes the count. When start and stop are written together, stop wins.
- R10: A write to either reload half stores that half, stops the counter and loads the counter with the new 32-bit reload value.
- R11: A read strobe returns the addressed register on `bus_rdata`, with `bus_rvalid` high, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| irq | output | 1 | Level interrupt: expired flag and enable |

## Verification
Two things can land on the same clock: software's clear write to the status word and a fresh expiry from the counter reaching zero. The bench runs the counter in auto-reload mode with a short reload value and counts clocks from the start strobe. It places the clear write on exactly the edge of the third expiry. It then judges at the next falling edge that `irq` is still high, which shows that the set won. A companion case counts the clocks to a snapshot write so that the capture lands on a count of 0x10000. It checks that both halves come back as 1 and 0, even though the live count has since borrowed across the halves.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int DFLT_DATA_W = 16;
    localparam int DFLT_ADDR_W = 3;

    typedef enum logic [2:0] {
        OFS_STATUS = 3'd0,
        OFS_CTRL   = 3'd1,
        OFS_RLD_LO = 3'd2,
        OFS_RLD_HI = 3'd3,
        OFS_SNP_LO = 3'd4,
        OFS_SNP_HI = 3'd5
    } reg_ofs_e;

    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_AUTO   = 1;
    localparam int CTL_GO     = 2;
    localparam int CTL_HALT   = 3;

    localparam int ST_EXPIRED = 0;
    localparam int ST_ACTIVE  = 1;

    typedef struct packed {
        logic ack_expiry;
        logic ctl_wr;
        logic go;
        logic halt;
        logic rld_lo_wr;
        logic rld_hi_wr;
        logic snap_wr;
    } wr_cmd_t;

    function automatic logic ofs_hit(input logic [2:0] a, input reg_ofs_e o);
        return a == o;
    endfunction

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
    import itmr_pkg::*;
#(
    parameter int ADDR_W = DFLT_ADDR_W
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              go_bit,
    input  logic              halt_bit,
    output wr_cmd_t           cmd
);
    localparam int HI_W = ADDR_W - 3;

    logic in_map;
    logic [2:0] low_addr;

    generate
        if (HI_W > 0) begin : g_wide
            assign in_map = (addr[ADDR_W-1:3] == '0);
        end else begin : g_narrow
            assign in_map = 1'b1;
        end
    endgenerate

    assign low_addr = addr[2:0];

    always_comb begin
        cmd            = '0;
        if (wr_en && in_map) begin
            cmd.ack_expiry = ofs_hit(low_addr, OFS_STATUS);
            cmd.ctl_wr     = ofs_hit(low_addr, OFS_CTRL);
            cmd.go         = ofs_hit(low_addr, OFS_CTRL) && go_bit;
            cmd.halt       = ofs_hit(low_addr, OFS_CTRL) && halt_bit;
            cmd.rld_lo_wr  = ofs_hit(low_addr, OFS_RLD_LO);
            cmd.rld_hi_wr  = ofs_hit(low_addr, OFS_RLD_HI);
            cmd.snap_wr    = ofs_hit(low_addr, OFS_SNP_LO) || ofs_hit(low_addr, OFS_SNP_HI);
        end
    end

endmodule

// File: rtl/itmr_core.sv
module itmr_core
    import itmr_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic              expired,
    output logic              active,
    output logic              irq_en,
    output logic              auto_mode,
    output logic [CNT_W-1:0]  reload,
    output logic [CNT_W-1:0]  snap
);
    logic [CNT_W-1:0] count;
    logic             at_zero;
    logic             expire_evt;
    logic             rld_wr;

    assign at_zero    = (count == '0);
    assign expire_evt = active && at_zero;
    assign rld_wr     = cmd.rld_lo_wr || cmd.rld_hi_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            reload    <= '0;
            snap      <= '0;
            active    <= 1'b0;
            expired   <= 1'b0;
            irq_en    <= 1'b0;
            auto_mode <= 1'b0;
        end else begin
            if (cmd.ctl_wr) begin
                irq_en    <= wdata[CTL_IRQ_EN];
                auto_mode <= wdata[CTL_AUTO];
            end

            if (expire_evt) begin
                count <= reload;
            end else if (active) begin
                count <= count - 1'b1;
            end

            if (cmd.rld_lo_wr) begin
                reload[DATA_W-1:0] <= wdata;
                count              <= {reload[CNT_W-1:DATA_W], wdata};
            end else if (cmd.rld_hi_wr) begin
                reload[CNT_W-1:DATA_W] <= wdata;
                count                  <= {wdata, reload[DATA_W-1:0]};
            end

            if (rld_wr || cmd.halt) begin
                active <= 1'b0;
            end else if (cmd.go) begin
                active <= 1'b1;
            end else if (expire_evt && !auto_mode) begin
                active <= 1'b0;
            end

            if (expire_evt) begin
                expired <= 1'b1;
            end else if (cmd.ack_expiry) begin
                expired <= 1'b0;
            end

            if (cmd.snap_wr) begin
                snap <= count;
            end
        end
    end

    p_expiry_flag_r3: assert property (@(posedge clk) disable iff (rst)
        active && count == '0 |=> expired);

    p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
        active && count != '0 && !rld_wr |=> count == CNT_W'($past(count) - 1'b1));

    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
        active && count == '0 && !auto_mode && !cmd.go |=> !active);

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        active && count == '0 && !rld_wr |=> count == $past(reload));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        cmd.ack_expiry && !(active && count == '0) |=> !expired);

    p_snap_capture_r8: assert property (@(posedge clk) disable iff (rst)
        cmd.snap_wr |=> snap == $past(count));

    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd.snap_wr |=> $stable(snap));

    p_halt_wins_r9: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> !active);

    p_reload_load_r10: assert property (@(posedge clk) disable iff (rst)
        rld_wr |=> !active && count == reload);

endmodule

// File: rtl/itmr_readback.sv
module itmr_readback
    import itmr_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int ADDR_W = DFLT_ADDR_W,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              expired,
    input  logic              active,
    input  logic              irq_en,
    input  logic              auto_mode,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  snap,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] mux_q;

    always_comb begin
        mux_q = '0;
        case (addr)
            ADDR_W'(OFS_STATUS): begin
                mux_q[ST_EXPIRED] = expired;
                mux_q[ST_ACTIVE]  = active;
            end
            ADDR_W'(OFS_CTRL): begin
                mux_q[CTL_IRQ_EN] = irq_en;
                mux_q[CTL_AUTO]   = auto_mode;
            end
            ADDR_W'(OFS_RLD_LO): mux_q = reload[DATA_W-1:0];
            ADDR_W'(OFS_RLD_HI): mux_q = reload[CNT_W-1:DATA_W];
            ADDR_W'(OFS_SNP_LO): mux_q = snap[DATA_W-1:0];
            ADDR_W'(OFS_SNP_HI): mux_q = snap[CNT_W-1:DATA_W];
            default:             mux_q = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= mux_q;
            end
        end
    end

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr > ADDR_W'(OFS_SNP_HI) |=> rvalid && rdata == '0);

    p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == ADDR_W'(OFS_STATUS) |=> rdata[DATA_W-1:2] == '0);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int ADDR_W = DFLT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    wr_cmd_t          cmd;
    logic             expired;
    logic             active;
    logic             irq_en;
    logic             auto_mode;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] snap;

    itmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .go_bit   (bus_wdata[CTL_GO]),
        .halt_bit (bus_wdata[CTL_HALT]),
        .cmd      (cmd)
    );

    itmr_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wdata     (bus_wdata),
        .expired   (expired),
        .active    (active),
        .irq_en    (irq_en),
        .auto_mode (auto_mode),
        .reload    (reload),
        .snap      (snap)
    );

    itmr_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_readback (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .expired   (expired),
        .active    (active),
        .irq_en    (irq_en),
        .auto_mode (auto_mode),
        .reload    (reload),
        .snap      (snap),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    assign irq = expired && irq_en;

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.ctl_wr && !bus_wdata[CTL_IRQ_EN] |=> !irq);

endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    interval_timer dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq        (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] expv, input string tag);
        bus_rd   = 1'b1;
        bus_addr = a;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd   = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard as read data appears
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R11: actual unexpected read data %0h expected none", bus_rdata);
            end else begin
                chk({16'h0, bus_rdata}, {16'h0, exp_q.pop_front()}, tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_n(3);
        rst = 1'b0;

        // R1 reset state
        chk(irq, 0, "R1 irq after reset");
        rd(3'd0, 16'h0000, "R1 status after reset");
        rd(3'd1, 16'h0000, "R1 control after reset");
        rd(3'd2, 16'h0000, "R1 reload low after reset");
        rd(3'd5, 16'h0000, "R1 snapshot high after reset");

        // R2 map, R11 read path
        wr(3'd2, 16'h0005);
        wr(3'd3, 16'h0000);
        rd(3'd2, 16'h0005, "R2 reload low readback");
        rd(3'd3, 16'h0000, "R2 reload high readback");
        rd(3'd6, 16'h0000, "R2 unmapped offset 6");
        rd(3'd7, 16'h0000, "R11 unmapped offset 7");

        // R3 one-shot interval of N+1 clocks, N=5
        wr(3'd1, 16'h0005);
        wait_n(5);
        chk(irq, 0, "R3 no expiry before N+1 clocks");
        wait_n(1);
        chk(irq, 1, "R3 expiry at N+1 clocks");
        rd(3'd0, 16'h0001, "R4 one-shot stops, flag set");
        rd(3'd1, 16'h0001, "R2 strobes read zero");
        wr(3'd5, 16'hBEEF);
        rd(3'd4, 16'h0005, "R4 counter reloaded after one-shot");
        rd(3'd5, 16'h0000, "R8 data ignored on snapshot write");

        // R7 clear
        wr(3'd0, 16'h0000);
        chk(irq, 0, "R7 status write clears");
        rd(3'd0, 16'h0000, "R7 status after clear");

        // R6 masked interrupt
        wr(3'd1, 16'h0004);
        wait_n(8);
        chk(irq, 0, "R6 irq masked when enable off");
        rd(3'd0, 16'h0001, "R6 flag visible while masked");
        wr(3'd0, 16'h1234);

        // R8 coherent capture across halfword borrow
        wr(3'd2, 16'h0002);
        wr(3'd3, 16'h0001);
        wr(3'd1, 16'h0004);
        wait_n(2);
        wr(3'd4, 16'h0000);
        rd(3'd4, 16'h0000, "R8 snapshot low at 0x10000");
        rd(3'd5, 16'h0001, "R8 snapshot high at 0x10000");
        rd(3'd4, 16'h0000, "R8 snapshot holds");
        wr(3'd1, 16'h0008);
        wr(3'd4, 16'h0000);
        rd(3'd4, 16'hFFF8, "R9 count frozen by stop");
        rd(3'd5, 16'h0000, "R9 frozen count high half");
        wait_n(5);
        wr(3'd5, 16'h0000);
        rd(3'd4, 16'hFFF8, "R9 count unchanged while stopped");
        rd(3'd0, 16'h0000, "R9 status after stop");

        // R9 start and stop together
        wr(3'd1, 16'h000C);
        rd(3'd0, 16'h0000, "R9 stop wins over start");

        // R10 reload write stops and loads
        wr(3'd1, 16'h0004);
        wait_n(3);
        wr(3'd2, 16'h0007);
        rd(3'd0, 16'h0000, "R10 reload write stops counter");
        wr(3'd5, 16'h0000);
        rd(3'd4, 16'h0007, "R10 counter loaded low");
        rd(3'd5, 16'h0001, "R10 counter loaded high");

        // R5 auto-reload, N=3, expiries at 4, 8, 12
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h0003);
        wr(3'd1, 16'h0007);
        wait_n(3);
        chk(irq, 0, "R5 before first expiry");
        wait_n(1);
        chk(irq, 1, "R5 first expiry");
        wr(3'd0, 16'h0000);
        chk(irq, 0, "R7 clear between expiries");
        wait_n(2);
        chk(irq, 0, "R5 before second expiry");
        wait_n(1);
        chk(irq, 1, "R5 second expiry after N+1");
        wait_n(3);
        wr(3'd0, 16'h0000);
        chk(irq, 1, "R7 expiry wins over same-cycle clear");
        rd(3'd0, 16'h0003, "R5 still active after expiry");
        wr(3'd1, 16'h0009);
        rd(3'd0, 16'h0001, "R9 stop in auto-reload");

        // R3 boundary: N=0
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd1, 16'h0005);
        chk(irq, 0, "R3 N=0 not yet expired");
        wait_n(1);
        chk(irq, 1, "R3 N=0 expires after one clock");

        wait_n(3);
        chk(exp_q.size(), 0, "R11 all reads returned");
        finish_run();
    end

endmodule